// File: doc/BRIEF.md
# Temperature-Adaptive DRAM Timing Enforcer

This block sits in a DRAM memory controller, next to the command scheduler. For each bank it keeps a small set of countdown counters. Every time a row-open, column read, column write or row-close command is issued, the block loads one or more of these counters. For the command the scheduler presents, it reports whether that command may be issued in the current cycle without breaking a timing constraint.

The constraint values are not fixed worst-case constants. The block holds five complete timing tuples: four tuned for temperature bins with upper edges at 55, 65, 75 and 85 °C, and one worst-case fallback. It follows a measured temperature and picks the tuple for the current bin. Moving to a cooler bin needs 2 °C of margin, so the selection does not toggle at a bin edge. A new tuple is copied as a whole into the working registers, and only when every bank counter has run out. The counters therefore never mix values from two tuples. Tuples are written in quarter-nanosecond units and rounded up to whole 1.25 ns command clocks as they are stored.

Top module: `dram_tadapt_timer`

## Requirements
- R1: After reset the active set index is 4, the working tuple is the worst-case one (sensing 11, restore 28, write recovery 12, precharge 11 cycles), and every command to every bank is allowed.
- R2: Commands are encoded as 0 = row open, 1 = read, 2 = write, 3 = row close. A read or write to a bank is allowed no earlier than N clock edges after a row open to that bank, where N is the working sensing value.
- R3: A row close to a bank is allowed no earlier than N edges after the last row open to it, where N is the working restore value.
- R4: A row close to a bank is allowed no earlier than N edges after the last write to it, where N is the working write-recovery value.
- R5: A row open to a bank is allowed no earlier than N edges after the last row close to it, where N is the working precharge value.
- R6: Counters are per bank. A command issued to one bank never blocks a command to another bank.
- R7: A table write stores, for each of the four values given in quarter nanoseconds q, the cycle count ceil(q/5), with a minimum of 1.
- R8: With temperature valid, the target set is 0 for readings at or below 55, 1 up to 65, 2 up to 75, and 3 up to 85. When all banks are idle, the set index output takes the new target on the second clock edge after the reading is applied.
- R9: A reading above 85 or an invalid reading selects set 4 at once, with no hysteresis.
- R10: The target moves to a cooler bin only when reading + 2 falls inside that bin. It moves to a hotter bin as soon as the reading enters it.
- R11: The active set and working tuple change only on an edge where all bank counters are zero and no command is issued. A pending change is held until then, and the whole tuple of the new set is applied together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_valid | input | 1 | Temperature reading is valid |
| temp_c | input | 8 | Temperature reading, whole °C |
| tbl_we | input | 1 | Write one whole tuple into the table |
| tbl_sel | input | 3 | Set index to write (0..4) |
| tbl_rcd_q | input | QW | Sensing time, quarter ns |
| tbl_ras_q | input | QW | Read restore time, quarter ns |
| tbl_wr_q | input | QW | Write recovery time, quarter ns |
| tbl_rp_q | input | QW | Precharge time, quarter ns |
| cmd_valid | input | 1 | Command presented and to be issued if allowed |
| cmd_type | input | 2 | Command code (see R2) |
| cmd_bank | input | log2(NBANK) | Target bank |
| issue_ok | output | 1 | The presented command meets all constraints this cycle |
| act_set | output | 3 | Index of the timing set in use |

## Verification
A counter that is loaded wrongly or decremented wrongly shows up as a shift in the first cycle issue_ok goes high for a dependent command. The bench probes every cycle of each gap, so an error of a single cycle is caught on the cycle where it occurs. A selection or switch fault shows on act_set within two edges of the temperature change, or, for a deferred switch, on the exact edge the last bank counter empties. A wrongly mixed or rounded tuple moves the gaps measured after a switch.

// File: rtl/dram_tadapt_timer.sv
module dram_tadapt_timer #(
  parameter int NBANK = 8,
  parameter int CW    = 6,
  parameter int QW    = 8,
  parameter int HYST  = 2,
  parameter int BIN0  = 55,
  parameter int BIN1  = 65,
  parameter int BIN2  = 75,
  parameter int BIN3  = 85,
  parameter int D_RCD = 11,
  parameter int D_RAS = 28,
  parameter int D_WR  = 12,
  parameter int D_RP  = 11,
  localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          temp_valid,
  input  logic [7:0]    temp_c,
  input  logic          tbl_we,
  input  logic [2:0]    tbl_sel,
  input  logic [QW-1:0] tbl_rcd_q,
  input  logic [QW-1:0] tbl_ras_q,
  input  logic [QW-1:0] tbl_wr_q,
  input  logic [QW-1:0] tbl_rp_q,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_type,
  input  logic [BW-1:0] cmd_bank,
  output logic          issue_ok,
  output logic [2:0]    act_set
);
  localparam int NSET = 5;
  localparam logic [2:0] FALLBACK = 3'd4;
  localparam logic [1:0] C_ACT = 2'd0, C_RD = 2'd1, C_WR = 2'd2, C_PRE = 2'd3;

  function automatic logic [CW-1:0] q2cyc(input logic [QW-1:0] q);
    logic [QW:0] c;
    c = ({1'b0, q} + (QW+1)'(4)) / (QW+1)'(5);
    if (c == '0) c = (QW+1)'(1);
    return CW'(c);
  endfunction

  function automatic logic [2:0] bin_of(input logic [8:0] t);
    if (t <= 9'(BIN0)) return 3'd0;
    if (t <= 9'(BIN1)) return 3'd1;
    if (t <= 9'(BIN2)) return 3'd2;
    if (t <= 9'(BIN3)) return 3'd3;
    return FALLBACK;
  endfunction

  logic [CW-1:0] t_rcd [NSET];
  logic [CW-1:0] t_ras [NSET];
  logic [CW-1:0] t_wr  [NSET];
  logic [CW-1:0] t_rp  [NSET];
  logic [CW-1:0] cur_rcd, cur_ras, cur_wr, cur_rp;
  logic [CW-1:0] cnt_rcd [NBANK];
  logic [CW-1:0] cnt_ras [NBANK];
  logic [CW-1:0] cnt_wr  [NBANK];
  logic [CW-1:0] cnt_rp  [NBANK];
  logic [2:0] want, want_nxt, hot, cool;
  logic all_idle, issued;

  assign issued = cmd_valid & issue_ok;
  assign hot    = bin_of({1'b0, temp_c});
  assign cool   = bin_of({1'b0, temp_c} + 9'(HYST));

  always_comb begin
    case (cmd_type)
      C_ACT:        issue_ok = (cnt_rp[cmd_bank] == '0);
      C_RD, C_WR:   issue_ok = (cnt_rcd[cmd_bank] == '0);
      default:      issue_ok = (cnt_ras[cmd_bank] == '0) && (cnt_wr[cmd_bank] == '0);
    endcase
  end

  always_comb begin
    all_idle = 1'b1;
    for (int b = 0; b < NBANK; b++)
      if ((cnt_rcd[b] | cnt_ras[b] | cnt_wr[b] | cnt_rp[b]) != '0) all_idle = 1'b0;
  end

  always_comb begin
    if (!temp_valid)      want_nxt = FALLBACK;
    else if (hot > want)  want_nxt = hot;
    else if (cool < want) want_nxt = cool;
    else                  want_nxt = want;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSET; s++) begin
        t_rcd[s] <= CW'(D_RCD);
        t_ras[s] <= CW'(D_RAS);
        t_wr[s]  <= CW'(D_WR);
        t_rp[s]  <= CW'(D_RP);
      end
    end else if (tbl_we && tbl_sel < 3'(NSET)) begin
      t_rcd[tbl_sel] <= q2cyc(tbl_rcd_q);
      t_ras[tbl_sel] <= q2cyc(tbl_ras_q);
      t_wr[tbl_sel]  <= q2cyc(tbl_wr_q);
      t_rp[tbl_sel]  <= q2cyc(tbl_rp_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      want    <= FALLBACK;
      act_set <= FALLBACK;
      cur_rcd <= CW'(D_RCD);
      cur_ras <= CW'(D_RAS);
      cur_wr  <= CW'(D_WR);
      cur_rp  <= CW'(D_RP);
    end else begin
      want <= want_nxt;
      if (all_idle && !issued && want != act_set) begin
        act_set <= want;
        cur_rcd <= t_rcd[want];
        cur_ras <= t_ras[want];
        cur_wr  <= t_wr[want];
        cur_rp  <= t_rp[want];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < NBANK; b++) begin
      if (!rst_n) begin
        cnt_rcd[b] <= '0;
        cnt_ras[b] <= '0;
        cnt_wr[b]  <= '0;
        cnt_rp[b]  <= '0;
      end else begin
        cnt_rcd[b] <= (issued && cmd_bank == BW'(b) && cmd_type == C_ACT) ? cur_rcd - 1'b1
                    : cnt_rcd[b] - CW'(cnt_rcd[b] != '0);
        cnt_ras[b] <= (issued && cmd_bank == BW'(b) && cmd_type == C_ACT) ? cur_ras - 1'b1
                    : cnt_ras[b] - CW'(cnt_ras[b] != '0);
        cnt_wr[b]  <= (issued && cmd_bank == BW'(b) && cmd_type == C_WR)  ? cur_wr - 1'b1
                    : cnt_wr[b] - CW'(cnt_wr[b] != '0);
        cnt_rp[b]  <= (issued && cmd_bank == BW'(b) && cmd_type == C_PRE) ? cur_rp - 1'b1
                    : cnt_rp[b] - CW'(cnt_rp[b] != '0);
      end
    end
  end
endmodule

// File: rtl/dram_tadapt_chk.sv
module dram_tadapt_chk #(
  parameter int NBANK = 8,
  parameter int CW    = 6,
  localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [1:0]    cmd_type,
  input logic [BW-1:0] cmd_bank,
  input logic          issue_ok,
  input logic [2:0]    act_set,
  input logic          all_idle,
  input logic          issued,
  input logic [CW-1:0] cur_rcd,
  input logic [CW-1:0] cur_ras,
  input logic [CW-1:0] cur_rp
);
  assert_switch_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_set) |-> $past(all_idle && !issued));

  assert_set_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    act_set <= 3'd4);

  assert_sense_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && issue_ok && cmd_type == 2'd0 && cur_rcd > 1)
    |=> !((cmd_type == 2'd1 || cmd_type == 2'd2) && cmd_bank == $past(cmd_bank) && issue_ok));

  assert_restore_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && issue_ok && cmd_type == 2'd0 && cur_ras > 1)
    |=> !(cmd_type == 2'd3 && cmd_bank == $past(cmd_bank) && issue_ok));

  assert_precharge_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && issue_ok && cmd_type == 2'd3 && cur_rp > 1)
    |=> !(cmd_type == 2'd0 && cmd_bank == $past(cmd_bank) && issue_ok));
endmodule

bind dram_tadapt_timer dram_tadapt_chk #(.NBANK(NBANK), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
  .cmd_bank(cmd_bank), .issue_ok(issue_ok), .act_set(act_set),
  .all_idle(all_idle), .issued(issued), .cur_rcd(cur_rcd),
  .cur_ras(cur_ras), .cur_rp(cur_rp)
);

// File: tb/dram_tadapt_timer_tb_top.sv
module dram_tadapt_timer_tb_top;
  logic clk = 0, rst_n = 0;
  logic temp_valid = 0;
  logic [7:0] temp_c = 0;
  logic tbl_we = 0;
  logic [2:0] tbl_sel = 0;
  logic [7:0] tbl_rcd_q = 0, tbl_ras_q = 0, tbl_wr_q = 0, tbl_rp_q = 0;
  logic cmd_valid = 0;
  logic [1:0] cmd_type = 0;
  logic [2:0] cmd_bank = 0;
  logic issue_ok;
  logic [2:0] act_set;

  always #4 clk = ~clk;

  dram_tadapt_timer dut_i (.*);

  typedef struct {
    bit    chk_ok;
    bit    exp_ok;
    int    exp_set;
    string tag;
  } exp_t;
  exp_t sb[$];
  int checks = 0, errors = 0;
  bit nt_v = 0;
  logic [7:0] nt_c = 0;
  bit done = 0;

  localparam logic [1:0] ACT = 2'd0, RD = 2'd1, WR = 2'd2, PRE = 2'd3;

  task automatic step(input bit v, input logic [1:0] ty, input logic [2:0] bk,
                      input bit eok, input int eset, input string tag);
    exp_t e;
    @(negedge clk);
    tbl_we = 0;
    temp_valid = nt_v;
    temp_c = nt_c;
    cmd_valid = v;
    cmd_type = ty;
    cmd_bank = bk;
    e.chk_ok = v; e.exp_ok = eok; e.exp_set = eset; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, ACT, 0, 0, -1, "");
  endtask

  task automatic gap(input logic [1:0] ty, input logic [2:0] bk, input int n, input string tag);
    for (int i = 1; i < n; i++) step(1, ty, bk, 0, -1, tag);
    step(1, ty, bk, 1, -1, tag);
  endtask

  task automatic expect_set(input int n, input int eset, input string tag);
    for (int i = 1; i < n; i++) step(0, ACT, 0, 0, -1, "");
    step(0, ACT, 0, 0, eset, tag);
  endtask

  task automatic wr_tbl(input logic [2:0] s, input logic [7:0] a, input logic [7:0] b,
                        input logic [7:0] c, input logic [7:0] d);
    exp_t e;
    @(negedge clk);
    cmd_valid = 0;
    tbl_we = 1; tbl_sel = s;
    tbl_rcd_q = a; tbl_ras_q = b; tbl_wr_q = c; tbl_rp_q = d;
    e.chk_ok = 0; e.exp_ok = 0; e.exp_set = -1; e.tag = "";
    sb.push_back(e);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        if (e.chk_ok) begin
          checks++;
          if (issue_ok !== e.exp_ok) begin
            errors++;
            $display("FAIL %s: issue_ok=%0b expected %0b", e.tag, issue_ok, e.exp_ok);
          end
        end
        if (e.exp_set >= 0) begin
          checks++;
          if (int'(act_set) != e.exp_set) begin
            errors++;
            $display("FAIL %s: act_set=%0d expected %0d", e.tag, act_set, e.exp_set);
          end
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: idle after reset, fallback set
    step(1, ACT, 0, 1, 4, "R1 reset allows command, set 4");
    gap(RD, 0, 11, "R2 default sensing 11");
    gap(PRE, 0, 17, "R3 default restore 28");
    gap(ACT, 0, 11, "R5 default precharge 11");
    step(1, ACT, 1, 1, -1, "R6 other bank unaffected");
    step(1, RD, 0, 0, -1, "R6 own bank still blocked");
    idle(30);
    step(1, WR, 0, 1, -1, "R4 write after sensing");
    gap(PRE, 0, 12, "R4 default write recovery 12");
    idle(15);
    // R7: set0 -> 9,18,6,8 ; set1 -> 10,24,8,9
    wr_tbl(3'd0, 8'd41, 8'd88, 8'd27, 8'd36);
    wr_tbl(3'd1, 8'd50, 8'd120, 8'd40, 8'd45);
    nt_v = 1; nt_c = 40;
    step(0, ACT, 0, 0, 4, "R8 set unchanged same cycle");
    step(0, ACT, 0, 0, 4, "R8 set unchanged first edge");
    step(0, ACT, 0, 0, 0, "R8 cool bin selected");
    step(1, ACT, 2, 1, -1, "R7 act on bank 2");
    gap(RD, 2, 9, "R7 rounded sensing 9");
    gap(PRE, 2, 9, "R7 rounded restore 18");
    gap(ACT, 2, 8, "R7 rounded precharge 8");
    idle(20);
    step(1, WR, 2, 1, -1, "R7 write bank 2");
    gap(PRE, 2, 6, "R7 rounded write recovery 6");
    idle(10);
    // R11: pending switch held while a counter runs
    nt_c = 95;
    step(1, ACT, 3, 1, 0, "R11 act issued with hot reading");
    for (int k = 1; k <= 18; k++) step(0, ACT, 0, 0, 0, "R11 switch held while busy");
    step(0, ACT, 0, 0, 4, "R9 over-limit fallback after idle");
    // R10 hysteresis
    nt_c = 60;
    expect_set(3, 1, "R8 bin 1 at 60");
    nt_c = 54;
    expect_set(3, 1, "R10 54 holds bin 1");
    expect_set(2, 1, "R10 54 still holds bin 1");
    nt_c = 53;
    expect_set(3, 0, "R10 53 moves to bin 0");
    nt_c = 56;
    expect_set(3, 1, "R10 56 moves hotter at once");
    // R11: whole tuple of set 1
    step(1, ACT, 4, 1, -1, "R11 act bank 4");
    gap(RD, 4, 10, "R11 set1 sensing 10");
    gap(PRE, 4, 14, "R11 set1 restore 24");
    gap(ACT, 4, 9, "R11 set1 precharge 9");
    idle(20);
    step(1, WR, 4, 1, -1, "R11 write bank 4");
    gap(PRE, 4, 8, "R11 set1 write recovery 8");
    idle(12);
    nt_c = 75;
    expect_set(3, 2, "R8 bin 2 at 75");
    nt_c = 86;
    expect_set(3, 4, "R9 86 falls back");
    nt_c = 70;
    expect_set(3, 2, "R8 back to bin 2 at 70");
    nt_v = 0;
    expect_set(3, 4, "R9 invalid reading falls back");
    idle(3);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule